// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block sits between a synchronous host and an asynchronous static RAM of 4096 four-bit words. The RAM has one active-low chip enable, one active-low write enable and a single bidirectional data bus. The host issues one single-word read or write at a time. The block turns each request into the enable and bus sequence the RAM needs, then returns a one-cycle completion strobe. For a read, the strobe comes with the captured word.

Every RAM timing minimum is set as a whole number of clock cycles, rounded up. The write-enable pulse width covers data setup and address-to-write-end. The access count covers address-to-data. Address, enables, output data and the output enable all come straight from registers, so no glitch reaches the RAM pins. The tri-state driver itself lives outside the block: it is controlled by `mem_doe` and fed from `mem_dout`. The block turns the driver on only while write enable is low, plus the single cycle after write enable rises. It turns the driver off in the same cycle that chip enable goes high. The RAM takes a few nanoseconds to drive after write enable rises, and that cycle falls inside the gap.

Top module: `asram_seq`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_we_n` are 1, and `mem_doe`, `done` and `rdata` are 0.
- R2: An accepted write (`req_wr`=1) first spends one cycle with `mem_ce_n`=0 and `mem_we_n`=1. It then holds `mem_we_n`=0 for exactly PULSE_CYC cycles. `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R3: During a write, `mem_doe` is 1 with `mem_dout` equal to the request data for the whole write-enable low window. It stays 1 for exactly one further cycle, with `mem_we_n`=1 and `mem_ce_n`=0. It is never 1 at any other time.
- R4: The cycle after that hold cycle has `mem_ce_n`=1, `mem_doe`=0 and `done`=1. `done` lasts exactly one cycle.
- R5: An accepted read (`req_wr`=0) holds `mem_ce_n`=0, `mem_we_n`=1 and `mem_doe`=0 for exactly ACCESS_CYC+1 cycles. The next cycle has `mem_ce_n`=1 and `done`=1.
- R6: A read samples `mem_din` at the last clock edge with `mem_ce_n`=0 and presents it on `rdata` in the `done` cycle. `rdata` then keeps that value until the next read completes.
- R7: `mem_addr` equals the accepted request address and stays constant for as long as `mem_ce_n` is 0.
- R8: `req` is sampled only in the idle state. A request presented while an operation or its `done` cycle is in progress is ignored: no other address, data or direction reaches the RAM.
- R9: A request held high across `done` is accepted at the second clock edge after the `done` cycle begins. Chip enable is then low again two cycles after `done`.
- R10: A read of any address returns the last data written there through the block (end-to-end through the RAM).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W | Last word read |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dout | output | DATA_W | Data toward the RAM bus driver |
| mem_doe | output | 1 | Bus driver enable, active high |
| mem_din | input | DATA_W | Data sampled from the RAM bus |

## Verification
A wrong state or counter value shows up at the pins in the very cycle it occurs. The enables, the driver enable or `done` then differ from the cycle-exact reference, and a stuck or mis-loaded timer stretches or shortens a pulse by at least one clock. A bad turnaround shows up as the bench RAM model driving the bus while `mem_doe` is high. A write that lands at the wrong address, or a request accepted while busy, corrupts RAM contents, and the later readback sweep exposes it.

// File: rtl/asq_pkg.sv
package asq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_W_SET   = 3'd1,
    ST_W_PULSE = 3'd2,
    ST_W_END   = 3'd3,
    ST_R_WAIT  = 3'd4,
    ST_DONE    = 3'd5
  } asq_state_e;
endpackage

// File: rtl/asq_rst_sync.sv
module asq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/asq_timer.sv
module asq_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 4,
  parameter int PULSE_CYC  = 3,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_doe,
  input  logic [DATA_W-1:0] mem_din
);
  localparam int MAX_CYC = (PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic rst_sn;
  asq_state_e state_q, state_d;
  logic              ce_q, ce_d, we_q, we_d, doe_q, doe_d, done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dout_q, dout_d, rdata_q, rdata_d;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;

  asq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  asq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_sn), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  // next-state and next-output logic
  always_comb begin
    state_d  = state_q;
    ce_d     = ce_q;
    we_d     = we_q;
    doe_d    = doe_q;
    addr_d   = addr_q;
    dout_d   = dout_q;
    rdata_d  = rdata_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          addr_d = req_addr;
          ce_d   = 1'b0;
          if (req_wr) begin
            dout_d  = req_wdata;
            state_d = ST_W_SET;
          end else begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACCESS_CYC);
            state_d  = ST_R_WAIT;
          end
        end
      end
      ST_W_SET: begin
        we_d     = 1'b0;
        doe_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC - 1);
        state_d  = ST_W_PULSE;
      end
      ST_W_PULSE: begin
        if (tmr_zero) begin
          we_d    = 1'b1;
          state_d = ST_W_END;
        end
      end
      ST_W_END: begin
        ce_d    = 1'b1;
        doe_d   = 1'b0;
        done_d  = 1'b1;
        state_d = ST_DONE;
      end
      ST_R_WAIT: begin
        if (tmr_zero) begin
          rdata_d = mem_din;
          ce_d    = 1'b1;
          done_d  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      doe_q   <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      dout_q  <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      we_q    <= we_d;
      doe_q   <= doe_d;
      done_q  <= done_d;
      addr_q  <= addr_d;
      dout_q  <= dout_d;
      rdata_q <= rdata_d;
    end
  end

  assign done     = done_q;
  assign rdata    = rdata_q;
  assign mem_addr = addr_q;
  assign mem_ce_n = ce_q;
  assign mem_we_n = we_q;
  assign mem_dout = dout_q;
  assign mem_doe  = doe_q;

  // write enable only inside chip enable (R2)
  p_we_under_ce_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !we_q |-> !ce_q);
  // driver on only while write enable low or the cycle after it rose (R3)
  p_drive_window_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    doe_q |-> (!we_q || $past(!we_q)));
  // completion strobe lasts one cycle with chip enable high (R4)
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |=> !done_q);
  p_done_deselect_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    done_q |-> (ce_q && !doe_q));
  // read wait keeps the bus released (R5)
  p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_R_WAIT) |-> (!doe_q && we_q && !ce_q));
  // address frozen while selected (R7)
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (!ce_q && $past(!ce_q)) |-> $stable(addr_q));
endmodule

// File: tb/asram_seq_bench.sv
`timescale 1ns/1ps
module asram_seq_bench;
  localparam int AW = 12, DW = 4, P = 3, A = 3;
  localparam int WR_END = P + 3, RD_END = A + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic done, mem_ce_n, mem_we_n, mem_doe;
  logic [DW-1:0] rdata, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  always #2.5 clk = ~clk;

  asram_seq #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(P), .ACCESS_CYC(A)) u_asram_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din)
  );

  int total = 0, bad = 0, cycles = 0;

  // ---------------- behavioural RAM (pin level) ----------------
  logic [DW-1:0] ram [4096];
  logic we_prev = 1'b1, ce_prev = 1'b1;
  logic [AW-1:0] addr_prev = '0;
  logic [DW-1:0] dout_prev = '0;
  logic ram_drv;
  // the RAM output turns on only after write enable has been high for a cycle
  assign ram_drv = !mem_ce_n && mem_we_n && we_prev;
  assign mem_din = ram_drv ? ram[mem_addr] : '0;

  // ---------------- reference model (cycle level) ----------------
  logic [DW-1:0] shadow [4096];
  int m_mode = 0, m_k = 0;          // 0 idle, 1 read, 2 write
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_data = '0, m_rdata = '0;
  logic model_on = 1'b0;

  always @(posedge clk) begin
    if (model_on) begin
      if (m_mode != 0) begin
        if ((m_mode == 1 && m_k == RD_END) || (m_mode == 2 && m_k == WR_END))
          m_mode = 0;
        else begin
          m_k = m_k + 1;
          if (m_mode == 1 && m_k == RD_END) m_rdata = shadow[m_addr];
          if (m_mode == 2 && m_k == WR_END) shadow[m_addr] = m_data;
        end
      end else if (req) begin
        m_mode = req_wr ? 2 : 1;
        m_k = 1;
        m_addr = req_addr;
        m_data = req_wdata;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and RAM behaviour, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (model_on) begin
      logic e_ce, e_we, e_doe, e_done;
      e_ce = 1; e_we = 1; e_doe = 0; e_done = 0;
      if (m_mode == 1) begin
        if (m_k <= A + 1) e_ce = 0; else e_done = 1;
      end else if (m_mode == 2) begin
        if (m_k <= P + 2) e_ce = 0;
        if (m_k >= 2 && m_k <= P + 1) e_we = 0;
        if (m_k >= 2 && m_k <= P + 2) e_doe = 1;
        if (m_k == WR_END) e_done = 1;
      end
      chk("R2/R5 ce_n", mem_ce_n, e_ce);
      chk("R2 we_n", mem_we_n, e_we);
      chk("R3 doe", mem_doe, e_doe);
      chk("R4 done", done, e_done);
      chk("R6 rdata", rdata, m_rdata);
      if (!e_ce) chk("R7/R8 addr", mem_addr, m_addr);
      if (e_doe) chk("R3 dout", mem_dout, m_data);
      if (ram_drv && mem_doe) chk("R3 bus contention", 1, 0);
      if (!ce_prev && !we_prev && !mem_ce_n && !mem_we_n)
        chk("R7 addr moved in write", mem_addr, addr_prev);
      if (!ce_prev && !we_prev && (mem_ce_n || mem_we_n))
        ram[addr_prev] = dout_prev;   // write ends on the rising edge
    end
    we_prev = mem_we_n; ce_prev = mem_ce_n;
    addr_prev = mem_addr; dout_prev = mem_dout;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog expired act=%0d exp<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  int last_done = 0;

  // one operation; junk requests are presented while busy (R8)
  task automatic op(input logic wr, input int addr, input int data, input bit b2b);
    req = 1'b1; req_wr = wr; req_addr = AW'(addr); req_wdata = DW'(data);
    do @(negedge clk); while (!(m_mode != 0 && m_k == 1));
    if (b2b) begin
      chk("R9 gap after done", cycles - last_done, 2);
      chk("R9 ce_n on accept", mem_ce_n, 0);
    end
    while (!done) begin
      req = 1'b1; req_wr = ~wr; req_addr = ~AW'(addr); req_wdata = ~DW'(data);
      @(negedge clk);
    end
    last_done = cycles;
    if (!wr) chk("R10 read data", rdata, shadow[addr]);
    req = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin ram[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    model_on = 1'b1;
    // R1 reset state
    chk("R1 ce_n", mem_ce_n, 1); chk("R1 we_n", mem_we_n, 1);
    chk("R1 doe", mem_doe, 0);   chk("R1 done", done, 0);
    chk("R1 rdata", rdata, 0);
    // corners and a basic round trip
    op(1, 12'h123, 4'hA, 0);
    op(0, 12'h123, 0, 0);
    op(1, 0, 4'h5, 0);
    op(1, 12'hFFF, 4'hF, 1);
    op(0, 0, 0, 1);
    op(0, 12'hFFF, 0, 1);
    op(0, 12'h7FF, 0, 1);  // unwritten location reads zero
    // pseudo-random mix, held back-to-back (R9)
    for (int i = 0; i < 60; i++) begin
      int a, d;
      a = (i * 397 + 11) % 4096;
      d = (i * 7 + 3) % 16;
      op((i % 3) != 2, a, d, 1);
    end
    // readback sweep: catches any ignored request that landed (R8, R10)
    for (int i = 0; i < 60; i++) op(0, (i * 397 + 11) % 4096, 0, 0);
    repeat (4) @(negedge clk);
    chk("R4 idle after run", done, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule